// File: doc/BRIEF.md
# Lockstep Multi-Lane Serial Receiver with Shared Ready Event

This block gathers serial audio-style data on several receive lanes at once. All lanes share one bit clock and one slot boundary. Each lane shifts its serial input into a private shift register, most significant bit first. When the final bit of a slot is captured, every enabled lane copies its completed word into its own read buffer in the same system clock cycle.

A single ready flag covers all lanes. Each transfer also produces one single-cycle DMA request pulse. Software or a DMA engine reads the lane buffers through a small register port. The flag clears in one of two ways: when a 1 is written to its status bit, or when every enabled lane buffer has been read since the last transfer. An interrupt output follows the flag when its enable bit is set. A sticky overrun bit records a transfer that overwrote an unread buffer.

The bit clock arrives asynchronously. It is synchronized into the system clock domain, together with the lane data, and only its rising edge is used. The slot bit counter runs freely from reset, so the first bit after reset starts a slot.

Top module: `lockstep_rx`

## Requirements
- R1: Each lane shifts in its word most significant bit first. Of the SLOT_W bits in a slot, the first received lands in bit SLOT_W-1 of the buffer and the last received lands in bit 0.
- R2: When the last bit of a slot is captured, every enabled lane writes its complete word into its read buffer, and the ready flag (status bit 0) sets in that same cycle.
- R3: A write to the status register with bit 0 at 1 clears the ready flag. A write with bit 0 at 0 leaves the flag unchanged.
- R4: Any lane-buffer read clears the ready flag if, after that read, no enabled lane still has an unread transfer.
- R5: Every transfer raises a DMA request, even if the ready flag is still set from an earlier transfer.
- R6: Each transfer produces exactly one DMA request pulse, one system clock wide, however many lanes are enabled.
- R7: The DMA request is high in the third system clock cycle after the bit clock's final rising edge of the slot reaches the input. This is within the 5-cycle limit.
- R8: A transfer that hits an enabled lane whose previous word was never read sets the overrun bit (status bit 1). The bit stays set until a 1 is written to status bit 1. Buffers always hold the newest word.
- R9: The interrupt output is high exactly while the ready flag is set and the interrupt enable (control register, address 1, bit 0) is 1.
- R10: A lane whose lane_en bit is 0 keeps its buffer through a transfer and is not counted for the automatic clear. If no lane is enabled, there is no transfer, no flag change and no request.
- R11: The register map is as follows. Address 0 is status: bit 0 is the ready flag and bit 1 is overrun, both write-1-to-clear. Address 1 is control: bit 0 is interrupt enable, read/write. Address 2+i reads lane i's buffer, zero-extended. reg_rdata reflects reg_addr in the same cycle. Any other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_clk | input | 1 | Receive bit clock, asynchronous; data captured on its rising edge |
| lane_sd | input | LANES | Serial data, one bit per lane |
| lane_en | input | LANES | Receiver enable mask, one bit per lane |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr |
| dma_req | output | 1 | One-cycle DMA request per transfer |
| irq | output | 1 | Ready interrupt |

## Verification
The hardest state to reach from the ports is a transfer landing on top of unread data: the ready flag still set, only some enabled lanes read, and the enable mask different from the previous slot's. Only then do the overrun, the repeated request and the partial automatic clear interact. The random phase gets there by changing the lane mask before every slot and then reading a random subset of lanes and writing random status values. As a result, many slots start with the flag set and stale lanes pending. Directed slots cover the edge cases: no lanes enabled, a write of 0, and back-to-back unread transfers.

// File: rtl/lockstep_rx_pkg.sv
package lockstep_rx_pkg;
    localparam int unsigned REG_STATUS    = 0;
    localparam int unsigned REG_CONTROL   = 1;
    localparam int unsigned REG_LANE_BASE = 2;
    localparam int unsigned STAT_READY_BIT = 0;
    localparam int unsigned STAT_OVR_BIT   = 1;
    localparam int unsigned CTRL_IE_BIT    = 0;
endpackage

// File: rtl/lockstep_rx_sync.sv
module lockstep_rx_sync #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_clk,
    input  logic [LANES-1:0] lane_sd,
    output logic             bit_tick,
    output logic [LANES-1:0] sd_sync
);
    typedef struct packed {
        logic [STAGES-1:0]            ck_pipe;
        logic [STAGES-1:0][LANES-1:0] sd_pipe;
        logic                         ck_last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.ck_pipe[0] = bit_clk;
        s_d.sd_pipe[0] = lane_sd;
        for (int k = 1; k < int'(STAGES); k++) begin
            s_d.ck_pipe[k] = s_q.ck_pipe[k-1];
            s_d.sd_pipe[k] = s_q.sd_pipe[k-1];
        end
        s_d.ck_last = s_q.ck_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_tick = s_q.ck_pipe[STAGES-1] & ~s_q.ck_last;
    assign sd_sync  = s_q.sd_pipe[STAGES-1];
endmodule

// File: rtl/lockstep_rx_slot.sv
module lockstep_rx_slot #(
    parameter int unsigned SLOT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    output logic last_bit
);
    localparam int unsigned CNT_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOT_W - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (bit_tick) cnt_d = (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_bit = bit_tick && (cnt_q == CNT_MAX);
endmodule

// File: rtl/lockstep_rx_lane.sv
module lockstep_rx_lane #(
    parameter int unsigned SLOT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              last_bit,
    input  logic              enable,
    input  logic              sd,
    output logic [SLOT_W-1:0] word
);
    typedef struct packed {
        logic [SLOT_W-1:0] shreg;
        logic [SLOT_W-1:0] rbuf;
    } lane_t;

    lane_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (bit_tick) l_d.shreg = {l_q.shreg[SLOT_W-2:0], sd};
        if (last_bit && enable) l_d.rbuf = {l_q.shreg[SLOT_W-2:0], sd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign word = l_q.rbuf;
endmodule

// File: rtl/lockstep_rx_ctrl.sv
module lockstep_rx_ctrl
    import lockstep_rx_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned SLOT_W = 16,
    parameter int unsigned REG_W  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    last_bit,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*SLOT_W-1:0] words,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    output logic                    xfer,
    output logic                    ready,
    output logic                    overrun,
    output logic                    irq_en,
    output logic                    dma_req,
    output logic                    irq
);
    typedef struct packed {
        logic             ready;
        logic             ovr;
        logic             ie;
        logic             dma;
        logic [LANES-1:0] pend;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [LANES-1:0] rd_hit;
    logic             rd_any;
    logic             wr_stat;
    logic             wr_ctrl;

    always_comb begin
        rd_hit = '0;
        for (int i = 0; i < int'(LANES); i++)
            rd_hit[i] = reg_rd && (reg_addr == ADDR_W'(REG_LANE_BASE + i));
        rd_any  = |rd_hit;
        wr_stat = reg_wr && (reg_addr == ADDR_W'(REG_STATUS));
        wr_ctrl = reg_wr && (reg_addr == ADDR_W'(REG_CONTROL));
        xfer    = last_bit && (|lane_en);
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(REG_STATUS)) begin
            reg_rdata[STAT_READY_BIT] = c_q.ready;
            reg_rdata[STAT_OVR_BIT]   = c_q.ovr;
        end else if (reg_addr == ADDR_W'(REG_CONTROL)) begin
            reg_rdata[CTRL_IE_BIT] = c_q.ie;
        end
        for (int i = 0; i < int'(LANES); i++)
            if (reg_addr == ADDR_W'(REG_LANE_BASE + i))
                reg_rdata[SLOT_W-1:0] = words[i*SLOT_W +: SLOT_W];
    end

    always_comb begin
        c_d     = c_q;
        c_d.dma = xfer;
        if (wr_ctrl) c_d.ie = reg_wdata[CTRL_IE_BIT];
        if (wr_stat && reg_wdata[STAT_OVR_BIT]) c_d.ovr = 1'b0;
        if (xfer) begin
            if (|(c_q.pend & lane_en & ~rd_hit)) c_d.ovr = 1'b1;
            c_d.pend  = lane_en;
            c_d.ready = 1'b1;
        end else begin
            c_d.pend = c_q.pend & ~rd_hit;
            if (wr_stat && reg_wdata[STAT_READY_BIT])
                c_d.ready = 1'b0;
            else if (rd_any && ((c_d.pend & lane_en) == '0))
                c_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ready   = c_q.ready;
    assign overrun = c_q.ovr;
    assign irq_en  = c_q.ie;
    assign dma_req = c_q.dma;
    assign irq     = c_q.ready & c_q.ie;
endmodule

// File: rtl/lockstep_rx.sv
module lockstep_rx #(
    parameter int unsigned LANES       = 4,
    parameter int unsigned SLOT_W      = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REG_W       = 32,
    parameter int unsigned ADDR_W      = $clog2(LANES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_clk,
    input  logic [LANES-1:0]  lane_sd,
    input  logic [LANES-1:0]  lane_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              dma_req,
    output logic              irq
);
    logic                    bit_tick;
    logic [LANES-1:0]        sd_sync;
    logic                    last_bit;
    logic [LANES*SLOT_W-1:0] words;
    logic                    xfer;
    logic                    ready;
    logic                    overrun;
    logic                    irq_en;

    lockstep_rx_sync #(.LANES(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .lane_sd(lane_sd),
        .bit_tick(bit_tick), .sd_sync(sd_sync)
    );

    lockstep_rx_slot #(.SLOT_W(SLOT_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .last_bit(last_bit)
    );

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        lockstep_rx_lane #(.SLOT_W(SLOT_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .last_bit(last_bit),
            .enable(lane_en[g]), .sd(sd_sync[g]),
            .word(words[g*SLOT_W +: SLOT_W])
        );
    end

    lockstep_rx_ctrl #(.LANES(LANES), .SLOT_W(SLOT_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .last_bit(last_bit), .lane_en(lane_en),
        .words(words), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer(xfer),
        .ready(ready), .overrun(overrun), .irq_en(irq_en),
        .dma_req(dma_req), .irq(irq)
    );
endmodule

// File: rtl/lockstep_rx_chk.sv
module lockstep_rx_chk #(
    parameter int unsigned REG_W  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer,
    input logic              ready,
    input logic              overrun,
    input logic              irq_en,
    input logic              dma_req,
    input logic              irq,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata
);
    // R6
    dma_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    // R5
    dma_every_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> dma_req);

    // R2
    ready_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> ready);

    // R9
    irq_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ready && irq_en));

    // R3
    write_zero_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !reg_rd && reg_wr && reg_addr == '0 && !reg_wdata[0]) |=> ready);

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(reg_wr && reg_addr == '0 && reg_wdata[1])) |=> overrun);
endmodule

bind lockstep_rx lockstep_rx_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .ready(ready), .overrun(overrun),
    .irq_en(irq_en), .dma_req(dma_req), .irq(irq), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_lockstep_rx.sv
`timescale 1ns/1ps
module sim_lockstep_rx;
    localparam int LANES = 4;
    localparam int SLOT_W = 16;
    localparam int ADDR_W = 3;
    localparam int REG_W = 32;
    localparam int HB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_clk = 1'b0;
    logic [LANES-1:0] lane_sd = '0;
    logic [LANES-1:0] lane_en = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic dma_req, irq;

    always #5 clk = ~clk;

    lockstep_rx #(.LANES(LANES), .SLOT_W(SLOT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .lane_sd(lane_sd),
        .lane_en(lane_en), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req), .irq(irq)
    );

    int tests = 0, fails = 0;
    int pulses = 0, wide = 0;
    logic dma_prev = 1'b0;

    logic [SLOT_W-1:0] m_buf [LANES];
    logic [LANES-1:0]  m_pend = '0;
    logic m_ready = 1'b0, m_ovr = 1'b0, m_ie = 1'b0;

    always @(negedge clk) begin
        if (dma_req) pulses++;
        if (dma_req && dma_prev) wide++;
        dma_prev = dma_req;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {30'd0, m_ovr, m_ready};
    endfunction

    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 0) begin
            if (d[0]) m_ready = 1'b0;
            if (d[1]) m_ovr = 1'b0;
        end else if (a == 1) m_ie = d[0];
    endtask

    task automatic reg_read(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a); reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        if (a >= 2 && a < 2 + LANES) begin
            m_pend[a-2] = 1'b0;
            if ((m_pend & lane_en) == '0) m_ready = 1'b0;
        end
    endtask

    task automatic peek(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
    endtask

    function automatic void model_xfer(input logic [LANES-1:0][SLOT_W-1:0] w);
        if (lane_en != '0) begin
            if ((m_pend & lane_en) != '0) m_ovr = 1'b1;
            for (int i = 0; i < LANES; i++) if (lane_en[i]) m_buf[i] = w[i];
            m_pend = lane_en;
            m_ready = 1'b1;
        end
    endfunction

    task automatic send_slot(input logic [LANES-1:0][SLOT_W-1:0] w, output int lat);
        lat = 0;
        for (int b = SLOT_W - 1; b >= 0; b--) begin
            @(negedge clk);
            bit_clk = 1'b0;
            for (int i = 0; i < LANES; i++) lane_sd[i] = w[i][b];
            repeat (HB - 1) @(negedge clk);
            bit_clk = 1'b1;
            if (b == 0) begin
                for (int k = 1; k <= HB + 1; k++) begin
                    @(negedge clk);
                    if (dma_req && lat == 0) lat = k;
                end
            end else begin
                repeat (HB - 1) @(negedge clk);
            end
        end
        model_xfer(w);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        peek(0, d); check({tag, " status R11"}, d, exp_status());
        for (int i = 0; i < LANES; i++) begin
            peek(2 + i, d); check({tag, " lane buffer R1"}, d, {16'd0, m_buf[i]});
        end
        check({tag, " irq R9"}, {31'd0, irq}, {31'd0, m_ready & m_ie});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [LANES-1:0][SLOT_W-1:0] w;
        logic [31:0] d;
        int lat, p0, junk;
        junk = int'($urandom(32'd20240611));
        for (int i = 0; i < LANES; i++) m_buf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state (R11)
        check_all("reset");
        check("reset dma R6", {31'd0, dma_req}, 32'd0);
        peek(1, d); check("reset ctrl R11", d, 32'd0);
        peek(7, d); check("unmapped R11", d, 32'd0);

        // R1 R2 R7 R6: first slot, all lanes
        lane_en = 4'hF;
        w[0] = 16'h8001; w[1] = 16'hA5C3; w[2] = 16'h0000; w[3] = 16'hFFFF;
        p0 = pulses;
        send_slot(w, lat);
        check("latency R7", lat, 3);
        check("one pulse R6", pulses - p0, 1);
        check_all("slot1 R2");

        // R4: auto clear after reading all enabled lanes
        for (int i = 0; i < LANES - 1; i++) reg_read(2 + i, d);
        peek(0, d); check("partial read keeps ready R4", d[0], 1);
        reg_read(2 + LANES - 1, d);
        peek(0, d); check("auto clear R4", d, exp_status());
        check("auto clear value R4", d[0], 0);

        // R3: write 0 no effect, write 1 clears
        w[0] = 16'h1234; w[1] = 16'h5678; w[2] = 16'h9ABC; w[3] = 16'hDEF0;
        send_slot(w, lat);
        reg_write(0, 32'h0);
        peek(0, d); check("write0 keeps ready R3", d[0], 1);
        reg_write(0, 32'h1);
        peek(0, d); check("write1 clears ready R3", d[0], 0);

        // R5 R8: unread data, two more transfers, flag never cleared
        p0 = pulses;
        send_slot(w, lat);
        w[2] = 16'h0F0F;
        send_slot(w, lat);
        check("repeated requests R5", pulses - p0, 2);
        peek(0, d); check("overrun set R8", d, exp_status());
        check("overrun bit R8", d[1], 1);
        check_all("overwrite R8");
        reg_write(0, 32'h1);
        peek(0, d); check("overrun sticky R8", d[1], 1);
        reg_write(0, 32'h2);
        peek(0, d); check("overrun clear R8", d[1], 0);

        // R9: interrupt gating
        send_slot(w, lat);
        check("irq off R9", {31'd0, irq}, 32'd0);
        reg_write(1, 32'h1);
        peek(1, d); check("ctrl readback R11", d, 32'd1);
        check("irq on R9", {31'd0, irq}, 32'd1);
        reg_write(0, 32'h1);
        check("irq after clear R9", {31'd0, irq}, 32'd0);

        // R10: disabled lanes and empty mask
        for (int i = 0; i < LANES; i++) reg_read(2 + i, d);
        lane_en = 4'b0101;
        w[0] = 16'hCAFE; w[1] = 16'hBEEF; w[2] = 16'h7777; w[3] = 16'h1111;
        send_slot(w, lat);
        check_all("masked R10");
        reg_read(2, d); reg_read(4, d);
        peek(0, d); check("masked auto clear R10", d[0], 0);
        lane_en = '0;
        p0 = pulses;
        send_slot(w, lat);
        check("empty mask no request R10", pulses - p0, 0);
        check_all("empty mask R10");

        // random phase
        for (int it = 0; it < 40; it++) begin
            lane_en = LANES'($urandom);
            for (int i = 0; i < LANES; i++) w[i] = SLOT_W'($urandom);
            p0 = pulses;
            send_slot(w, lat);
            check("random requests R5", pulses - p0, (lane_en != '0) ? 1 : 0);
            if (lane_en != '0) check("random latency R7", lat, 3);
            for (int r = 0; r < 3; r++) begin
                int a;
                a = 2 + int'($urandom % LANES);
                if ($urandom % 2 == 0) begin
                    reg_read(a, d);
                    check("random lane read R1", d, {16'd0, m_buf[a-2]});
                end
            end
            if ($urandom % 4 == 0) reg_write(0, 32'($urandom % 4));
            if ($urandom % 4 == 0) reg_write(1, 32'($urandom % 2));
            check_all("random R4");
        end

        check("no wide pulse R6", wide, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule